// File: doc/BRIEF.md
# Registered-Output Programmable Array Logic

This block models a small sequential programmable logic device. Eight dedicated input pins, four register feedback signals and four bidirectional pin values form sixteen signals. The array offers each of them as a true and a complement literal, which gives 32 literal columns. Every output owns eight product-term rows of the programmable AND array, and each row ANDs the literals whose fuses are left intact. The OR side is fixed wiring.

Four outputs are registered. Each one samples the OR of its eight rows into a D flip-flop on the common clock. It reaches its pin through an inverting tri-state driver, and one active-low enable pin controls all four drivers. The flip-flop state returns to the array, so the fuse map can describe counters and Mealy or Moore state machines. The other four outputs are combinational bidirectional pins. On each of them, the first row is a private drive enable and the remaining seven rows are ORed into the pin value. Whatever value is present on such a pin returns to the array as a literal.

The fuse map is a serial shift chain loaded through a configuration port. Tri-state pins are modelled as a value output plus a drive-enable output.

Top module: `pal_registered`

## Requirements
- R1: While `rst` is high on a clock edge, every fuse becomes intact and every flip-flop clears. After reset `reg_pin_n` reads 4'hF and `io_oe` reads 0 until a map is loaded.
- R2: Each clock edge with `cfg_en` high shifts `cfg_bit` into the top of the chain. After 2048 shifts the first bit sent sits at fuse index 0. Fuse index = row*32 + column. Row = output*8 + term, where outputs 0..3 are the registers and 4..7 are bidirectional pins 0..3. Column = 2*signal + polarity, where polarity 0 is true and 1 is complement. Signal numbers are: inputs 0..7, register feedback 8..11, bidirectional pins 12..15. A fuse bit of 1 is intact (the literal is connected) and 0 is blown.
- R3: On every clock edge with `cfg_en` high, all four flip-flops clear instead of loading their sums.
- R4: A row is the AND of the literals whose fuses are intact. A row with every fuse intact is 0, because it holds a signal and its complement. A row with every fuse blown is 1.
- R5: Each flip-flop loads the OR of its eight rows on the rising clock edge, and `reg_pin_n` shows the complement of the flip-flop state.
- R6: `reg_oe` is 1 exactly when `oe_n` is 0. The flip-flops keep updating and feeding back while the drivers are off.
- R7: Register feedback is the true flip-flop state, so a row can depend on the machine's own present state.
- R8: For bidirectional pin k, row 0 drives `io_oe[k]`, and the OR of rows 1..7 drives `io_out[k]`, both combinationally.
- R9: `io_in` enters the array as a literal whatever the state of `io_oe`.
- R10: With `cfg_en` low, the fuse map does not change, whatever the value of `cfg_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the flip-flops and the fuse chain |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the fuse chain |
| cfg_bit | input | 1 | Serial fuse data |
| oe_n | input | 1 | Active-low enable for the registered pin drivers |
| in_pins | input | 8 | Dedicated input pins |
| io_in | input | 4 | Values present on the bidirectional pins |
| reg_pin_n | output | 4 | Inverted flip-flop state driven to the registered pins |
| reg_oe | output | 1 | Drive enable of the registered pins |
| io_out | output | 4 | Value driven on each bidirectional pin |
| io_oe | output | 4 | Drive enable of each bidirectional pin |

## Verification
The assertions check four things on every cycle: the chain shift and hold rules, the fuse state after reset, the clearing of the flip-flops during loading, and the rule that an all-intact map holds every flip-flop at zero. Other behaviour depends on a particular fuse map: how literals combine into rows, the OR of several rows, the drive-enable row of a bidirectional pin, and state machines built from feedback. Only the bench scenarios can show these. They load chosen maps and follow the pins through known sequences, including a stretch with the registered drivers switched off.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
    localparam int N_IN  = 8;
    localparam int N_REG = 4;
    localparam int N_IO  = 4;
    localparam int TERMS = 8;
    localparam int N_SIG = N_IN + N_REG + N_IO;
    localparam int COLS  = 2 * N_SIG;
    localparam int N_OUT = N_REG + N_IO;
    localparam int ROWS  = N_OUT * TERMS;
    localparam int FUSES = ROWS * COLS;

    // Signals seen by the array; packed so that inputs take the low indices.
    typedef struct packed {
        logic [N_IO-1:0]  io;
        logic [N_REG-1:0] fb;
        logic [N_IN-1:0]  pin;
    } sig_t;

    function automatic logic [COLS-1:0] expand(input sig_t s);
        logic [N_SIG-1:0] v;
        logic [COLS-1:0]  c;
        v = s;
        for (int i = 0; i < N_SIG; i++) begin
            c[2*i]   = v[i];
            c[2*i+1] = ~v[i];
        end
        return c;
    endfunction
endpackage

// File: rtl/pal_fuse_store.sv
`timescale 1ns/1ps
module pal_fuse_store
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [FUSES-1:0] fuse
);
    always_ff @(posedge clk) begin
        if (rst)
            fuse <= '1;
        else if (cfg_en)
            fuse <= {cfg_bit, fuse[FUSES-1:1]};
    end

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> fuse[FUSES-1] == $past(cfg_bit));
    // R10
    hold_map_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(fuse));
    // R1
    reset_intact_chk: assert property (@(posedge clk)
        rst |=> &fuse);
endmodule

// File: rtl/pal_and_plane.sv
`timescale 1ns/1ps
module pal_and_plane
    import pal_pkg::*;
(
    input  logic [COLS-1:0]  lit,
    input  logic [FUSES-1:0] fuse,
    output logic [ROWS-1:0]  pterm
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign pterm[r] = &(~fuse[r*COLS +: COLS] | lit);
    end
endmodule

// File: rtl/pal_or_plane.sv
`timescale 1ns/1ps
module pal_or_plane
    import pal_pkg::*;
(
    input  logic [ROWS-1:0]  pterm,
    output logic [N_REG-1:0] reg_d,
    output logic [N_IO-1:0]  io_en,
    output logic [N_IO-1:0]  io_sum
);
    for (genvar o = 0; o < N_REG; o++) begin : g_reg
        assign reg_d[o] = |pterm[o*TERMS +: TERMS];
    end
    for (genvar k = 0; k < N_IO; k++) begin : g_io
        localparam int BASE = (N_REG + k) * TERMS;
        assign io_en[k]  = pterm[BASE];
        assign io_sum[k] = |pterm[BASE+1 +: TERMS-1];
    end
endmodule

// File: rtl/pal_registered.sv
`timescale 1ns/1ps
module pal_registered
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic             oe_n,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_IO-1:0]  io_in,
    output logic [N_REG-1:0] reg_pin_n,
    output logic             reg_oe,
    output logic [N_IO-1:0]  io_out,
    output logic [N_IO-1:0]  io_oe
);
    logic [FUSES-1:0] fuse;
    logic [ROWS-1:0]  pterm;
    logic [N_REG-1:0] q;
    logic [N_REG-1:0] reg_d;
    logic [COLS-1:0]  lit;
    sig_t             sv;

    pal_fuse_store u_store (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .fuse(fuse)
    );

    always_comb begin
        sv.pin = in_pins;
        sv.fb  = q;
        sv.io  = io_in;
        lit    = expand(sv);
    end

    pal_and_plane u_and (.lit(lit), .fuse(fuse), .pterm(pterm));

    pal_or_plane u_or (
        .pterm(pterm), .reg_d(reg_d), .io_en(io_oe), .io_sum(io_out)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_en)
            q <= '0;
        else
            q <= reg_d;
    end

    assign reg_pin_n = ~q;
    assign reg_oe    = ~oe_n;

    // R3
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> q == '0);
    // R4
    intact_map_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (&fuse) |=> q == '0);
endmodule

// File: tb/tb_pal_registered.sv
`timescale 1ns/1ps
module tb_pal_registered;
    import pal_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_bit = 1'b0;
    logic oe_n = 1'b0;
    logic [N_IN-1:0]  in_pins = '0;
    logic [N_IO-1:0]  io_in = '0;
    logic [N_REG-1:0] reg_pin_n;
    logic             reg_oe;
    logic [N_IO-1:0]  io_out;
    logic [N_IO-1:0]  io_oe;

    int errors = 0;
    int checks = 0;
    logic [FUSES-1:0] fm;

    always #4 clk = ~clk;

    pal_registered dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .oe_n(oe_n),
        .in_pins(in_pins), .io_in(io_in), .reg_pin_n(reg_pin_n), .reg_oe(reg_oe),
        .io_out(io_out), .io_oe(io_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Map helpers: row for output o term t; signal s; neg selects complement
    task automatic map_blank();
        fm = '1;
    endtask
    task automatic row_open(input int o, input int t);
        fm[(o*TERMS+t)*COLS +: COLS] = '0;
    endtask
    task automatic add_lit(input int o, input int t, input int s, input int neg);
        fm[(o*TERMS+t)*COLS + 2*s + neg] = 1'b1;
    endtask

    task automatic load_map(input bit check_clear);
        for (int i = 0; i < FUSES; i++) begin
            cfg_en  = 1'b1;
            cfg_bit = fm[i];
            step();
            if (check_clear && i == 0)
                chk("R3 registers cleared by load", 8'(reg_pin_n), 8'hF);
        end
        cfg_en  = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk("R1 reset pins", 8'(reg_pin_n), 8'hF);
        chk("R1 reset io enables", 8'(io_oe), 8'h0);
        chk("R6 driver on", 8'(reg_oe), 8'h1);
        rst = 1'b0;
        in_pins = 8'hA5;
        io_in = 4'hF;
        step(); step(); step();
        chk("R4 intact rows stay 0", 8'(reg_pin_n), 8'hF);
        chk("R4 intact io rows", 8'(io_oe), 8'h0);
    endtask

    task automatic t_comb();
        map_blank();
        row_open(4, 0);                          // io0 always driven
        row_open(4, 1); add_lit(4, 1, 0, 0); add_lit(4, 1, 1, 1);
        row_open(5, 0); add_lit(5, 0, 2, 0);     // io1 enable = in2
        row_open(5, 1); add_lit(5, 1, 15, 0);    // io1 sum = io_in[3]
        load_map(1'b0);
        in_pins = 8'h01; io_in = 4'h0; #1;
        chk("R8 io0 enabled", 8'(io_oe[0]), 8'h1);
        chk("R8 io0 term true", 8'(io_out[0]), 8'h1);
        in_pins = 8'h03; #1;
        chk("R4 complement literal kills term", 8'(io_out[0]), 8'h0);
        chk("R8 io1 disabled", 8'(io_oe[1]), 8'h0);
        in_pins = 8'h04; io_in = 4'h8; #1;
        chk("R8 io1 enabled", 8'(io_oe[1]), 8'h1);
        chk("R9 io_in feedback high", 8'(io_out[1]), 8'h1);
        chk("R4 unused io stays off", 8'(io_oe[3:2]), 8'h0);
        io_in = 4'h0; #1;
        chk("R9 io_in feedback low", 8'(io_out[1]), 8'h0);
        rst = 1'b1; in_pins = 8'h01;
        step();
        rst = 1'b0; #1;
        chk("R1 reset restores intact fuses", 8'(io_oe), 8'h0);
    endtask

    task automatic build_reg_map();
        map_blank();
        row_open(0, 0); add_lit(0, 0, 8, 1);     // q0 <= ~q0
        row_open(1, 0); add_lit(1, 0, 0, 0);     // q1 <= in0
        row_open(2, 0); add_lit(2, 0, 4, 0);     // q2 <= in4 | in5
        row_open(2, 1); add_lit(2, 1, 5, 0);
        row_open(3, 0); add_lit(3, 0, 9, 0);     // q3 <= q1
    endtask

    task automatic t_reg();
        build_reg_map();
        in_pins = '0;
        load_map(1'b0);
        chk("R3 cleared after load", 8'(reg_pin_n), 8'hF);
        step();
        chk("R5 first edge", 8'(reg_pin_n), 8'hE);
        in_pins = 8'h21;
        step();
        chk("R5 OR of two rows", 8'(reg_pin_n), 8'h9);
        in_pins = 8'h10;
        step();
        chk("R7 feedback state machine", 8'(reg_pin_n), 8'h2);
        in_pins = 8'h00;
        step();
        chk("R7 feedback back to zero", 8'(reg_pin_n), 8'hF);
    endtask

    task automatic t_oe();
        oe_n = 1'b1; in_pins = 8'h01; #1;
        chk("R6 drivers off", 8'(reg_oe), 8'h0);
        step(); step();
        oe_n = 1'b0; in_pins = 8'h00; #1;
        chk("R6 drivers on", 8'(reg_oe), 8'h1);
        chk("R6 state advanced while off", 8'(reg_pin_n), 8'h5);
    endtask

    task automatic t_reload_hold();
        build_reg_map();
        load_map(1'b1);
        in_pins = '0;
        step();
        chk("R2 reload order", 8'(reg_pin_n), 8'hE);
        for (int i = 0; i < 20; i++) begin
            cfg_bit = i[0];
            step();
        end
        cfg_bit = 1'b0;
        chk("R10 map held with cfg_en low", 8'(reg_pin_n), 8'hE);
        step();
        chk("R10 toggle still intact", 8'(reg_pin_n), 8'hF);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_comb();
        t_reg();
        t_oe();
        t_reload_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule